// File: doc/BRIEF.md
# Card Clock Generator with Deferred Update

This block derives the clock that drives a memory card from the controller clock. An even divider and a run/stop enable set the card clock. Software never changes them directly. Writes to the divider, the source select and the enable only fill shadow registers. Nothing on the card side moves until software issues an update command by writing a command word with its start bit set. The start bit reads back through `upd_busy` until the shadow values have been copied into the live registers, and then it clears on its own. Software polls it to learn when the change is done.

An update command may ask to wait for the previous data transfer. The load is then held off for as long as `xfer_busy` is high. Every change of the live settings happens while the divided clock is in its low phase. The mux select and the gate are re-timed to the falling edge of the controller clock, so the card clock never shows a shortened pulse. The intended software sequence has three updates: stop the clock, then set the divider and source, then start the clock again.

Top module: `sdclk_gen`

## Requirements
- R1: After reset `card_clk` is low, `upd_busy` is low, `src_sel` is 0, and the live divider is 0 with the clock stopped.
- R2: Writes to the divider (`wr_sel`=0, bits [7:0]), source (`wr_sel`=1, bits [1:0]) or enable (`wr_sel`=2, bit 0) registers leave `card_clk` and `src_sel` unchanged until an update command completes.
- R3: A command write (`wr_sel`=3) with bit 7 set, made while idle, sets `upd_busy` in the next cycle. `upd_busy` clears by itself once the shadow values are live.
- R4: If command bit 6 (wait for data) is set, the load is held and the old clock keeps running for as long as `xfer_busy` is high. The load follows once `xfer_busy` falls.
- R5: If command bit 6 is clear, `xfer_busy` has no effect and the update completes.
- R6: A live divider of 0 with the clock enabled passes the controller clock to `card_clk` unchanged.
- R7: A live divider N > 0 with the clock enabled gives a `card_clk` that is high for N controller cycles and low for N, so its period is 2·N.
- R8: A live enable of 0 holds `card_clk` low.
- R9: New settings are loaded only while the divided clock is in its low phase.
- R10: A command write made while an update is pending is ignored. It neither restarts the pending update nor replaces its wait-for-data choice.
- R11: A command write with bit 7 clear starts no update.
- R12: The source select reaches `src_sel` only when an update completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, also the undivided card clock source |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 divider, 1 source, 2 enable, 3 command |
| wr_data | input | DATA_W | Write data |
| xfer_busy | input | 1 | High while a data transfer is in progress |
| upd_busy | output | 1 | Start bit readback: high while an update is pending |
| src_sel | output | SRC_W | Live clock source select |
| card_clk | output | 1 | Gated, divided card clock |

## Verification
The hardest situation to reach is an update that is pending behind a data transfer while a second command arrives. The bench holds `xfer_busy` high and issues a waiting update. It then issues another command without the wait flag, and it measures the old clock period while both commands are outstanding, to show that nothing has moved. Only then does it release `xfer_busy` and measure the new period. Switches between the pass-through and divided modes are also made while the clock runs, with the falling-edge re-timing in the path.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  typedef enum logic [1:0] {
    REG_DIV = 2'd0,
    REG_SRC = 2'd1,
    REG_ENA = 2'd2,
    REG_CMD = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    UPD_IDLE = 2'd0,
    UPD_HOLD = 2'd1,
    UPD_SYNC = 2'd2
  } upd_st_e;

  localparam int CMD_START_BIT = 7;
  localparam int CMD_WAIT_BIT  = 6;

  // Last controller cycle of a half period for divider value div.
  function automatic logic half_last(input int unsigned cnt, input int unsigned div);
    return (cnt + 1) >= div;
  endfunction

endpackage

// File: rtl/sdclk_regs.sv
module sdclk_regs
  import sdclk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int SRC_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DIV_W-1:0]  sh_div,
  output logic [SRC_W-1:0]  sh_src,
  output logic              sh_en,
  output logic              cmd_start,
  output logic              cmd_wait
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_div <= '0;
      sh_src <= '0;
      sh_en  <= 1'b0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        REG_DIV: sh_div <= wr_data[DIV_W-1:0];
        REG_SRC: sh_src <= wr_data[SRC_W-1:0];
        REG_ENA: sh_en  <= wr_data[0];
        default: ;
      endcase
    end
  end

  assign cmd_start = wr_en && (reg_sel_e'(wr_sel) == REG_CMD) && wr_data[CMD_START_BIT];
  assign cmd_wait  = wr_data[CMD_WAIT_BIT];

endmodule

// File: rtl/sdclk_upd_ctrl.sv
module sdclk_upd_ctrl
  import sdclk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_start,
  input  logic cmd_wait,
  input  logic xfer_busy,
  input  logic phase_low,
  output logic busy,
  output logic in_hold,
  output logic load_evt
);

  upd_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      UPD_IDLE: if (cmd_start) st_d = cmd_wait ? UPD_HOLD : UPD_SYNC;
      UPD_HOLD: if (!xfer_busy) st_d = UPD_SYNC;
      UPD_SYNC: if (phase_low) st_d = UPD_IDLE;
      default:  st_d = UPD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= UPD_IDLE;
    else        st_q <= st_d;
  end

  assign busy     = (st_q != UPD_IDLE);
  assign in_hold  = (st_q == UPD_HOLD);
  assign load_evt = (st_q == UPD_SYNC) && phase_low;

endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
  import sdclk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_evt,
  input  logic [DIV_W-1:0] new_div,
  input  logic             new_en,
  output logic             div_phase,
  output logic             phase_low,
  output logic             card_clk
);

  logic [DIV_W-1:0] act_div, cnt_q;
  logic             act_en;
  logic             gate_q, byp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_div   <= '0;
      act_en    <= 1'b0;
      cnt_q     <= '0;
      div_phase <= 1'b0;
    end else if (load_evt) begin
      act_div   <= new_div;
      act_en    <= new_en;
      cnt_q     <= '0;
      div_phase <= 1'b0;
    end else if (act_div == '0) begin
      cnt_q     <= '0;
      div_phase <= 1'b0;
    end else if (half_last(32'(cnt_q), 32'(act_div))) begin
      cnt_q     <= '0;
      div_phase <= ~div_phase;
    end else begin
      cnt_q     <= cnt_q + 1'b1;
    end
  end

  // Gate and mode select move only on the falling edge, while clk is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      byp_q  <= 1'b1;
    end else begin
      gate_q <= act_en;
      byp_q  <= (act_div == '0);
    end
  end

  assign phase_low = (act_div == '0) || !div_phase;
  assign card_clk  = gate_q & (byp_q ? clk : div_phase);

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
  import sdclk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int SRC_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              xfer_busy,
  output logic              upd_busy,
  output logic [SRC_W-1:0]  src_sel,
  output logic              card_clk
);

  logic [DIV_W-1:0] sh_div;
  logic [SRC_W-1:0] sh_src;
  logic             sh_en, cmd_start, cmd_wait, cmd_accept;
  logic             phase_low, div_phase, in_hold, load_evt;

  sdclk_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W), .SRC_W(SRC_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sh_div(sh_div), .sh_src(sh_src), .sh_en(sh_en),
    .cmd_start(cmd_start), .cmd_wait(cmd_wait)
  );

  assign cmd_accept = cmd_start && !upd_busy;

  sdclk_upd_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_accept), .cmd_wait(cmd_wait),
    .xfer_busy(xfer_busy), .phase_low(phase_low),
    .busy(upd_busy), .in_hold(in_hold), .load_evt(load_evt)
  );

  sdclk_divider #(.DIV_W(DIV_W)) div_i (
    .clk(clk), .rst_n(rst_n), .load_evt(load_evt), .new_div(sh_div), .new_en(sh_en),
    .div_phase(div_phase), .phase_low(phase_low), .card_clk(card_clk)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        src_sel <= '0;
    else if (load_evt) src_sel <= sh_src;
  end

endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic              xfer_busy,
  input logic              upd_busy,
  input logic              in_hold,
  input logic              load_evt,
  input logic              div_phase
);

  logic cmd_wr;
  assign cmd_wr = wr_en && (wr_sel == 2'd3) && wr_data[7];

  p_busy_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !upd_busy) |=> upd_busy);

  p_self_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> !upd_busy);

  p_hold_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hold && xfer_busy) |=> !load_evt);

  p_load_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> !div_phase);

  p_start_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_busy) |-> $past(cmd_wr));

  p_load_needs_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> upd_busy);

endmodule

bind sdclk_gen sdclk_gen_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .xfer_busy(xfer_busy), .upd_busy(upd_busy), .in_hold(in_hold),
  .load_evt(load_evt), .div_phase(div_phase)
);

// File: tb/sdclk_gen_tb_top.sv
module sdclk_gen_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       xfer_busy = 1'b0;
  logic       upd_busy;
  logic [1:0] src_sel;
  logic       card_clk;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  sdclk_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .xfer_busy(xfer_busy), .upd_busy(upd_busy), .src_sel(src_sel), .card_clk(card_clk)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  // Command: bit 7 start, bit 6 wait for data.
  task automatic issue(input bit start, input bit wt);
    reg_wr(2'd3, {start, wt, 6'd0});
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (upd_busy && n < 2000) begin
      @(negedge clk); #1; n++;
    end
    chk(!upd_busy, tag, int'(upd_busy), 0);
  endtask

  task automatic check_off(input string tag);
    int highs = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1; if (card_clk) highs++;
      @(negedge clk); #1; if (card_clk) highs++;
    end
    chk(highs == 0, tag, highs, 0);
  endtask

  task automatic check_bypass(input string tag);
    int bad = 0;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1; if (!card_clk) bad++;
      @(negedge clk); #1; if (card_clk) bad++;
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic check_div(input int n, input string tag);
    int hi = 0, lo = 0, guard = 0;
    logic prev = 1'b1;
    logic cur;
    // locate a rising edge in the high-phase samples
    forever begin
      @(posedge clk); #1; cur = card_clk; guard++;
      if (cur && !prev) break;
      prev = cur;
      if (guard > 4*n + 8) break;
    end
    hi = 1;
    for (int i = 0; i < 2*n + 4; i++) begin
      @(posedge clk); #1;
      if (!card_clk) break;
      hi++;
    end
    lo = 1;
    for (int i = 0; i < 2*n + 4; i++) begin
      @(posedge clk); #1;
      if (card_clk) break;
      lo++;
    end
    chk(hi == n, {tag, " high"}, hi, n);
    chk(lo == n, {tag, " low"}, lo, n);
  endtask

  task automatic t_reset;
    chk(card_clk == 1'b0, "R1 card_clk", int'(card_clk), 0);
    chk(upd_busy == 1'b0, "R1 busy", int'(upd_busy), 0);
    chk(src_sel == 2'd0, "R1 src_sel", int'(src_sel), 0);
    check_off("R1 stopped");
  endtask

  task automatic t_no_start;
    reg_wr(2'd2, 8'd1);
    issue(1'b0, 1'b0);               // R11: start bit clear
    chk(!upd_busy, "R11 busy", int'(upd_busy), 0);
    check_off("R11 clock still off");
    check_off("R2 enable shadow not live");
  endtask

  task automatic t_bypass_on;
    issue(1'b1, 1'b0);
    chk(upd_busy, "R3 busy set", int'(upd_busy), 1);
    wait_done("R3 self clear");
    check_bypass("R6 pass-through");
  endtask

  task automatic t_change_seq;
    reg_wr(2'd2, 8'd0);
    issue(1'b1, 1'b0);
    wait_done("R3 stop update");
    check_off("R8 disabled");
    reg_wr(2'd0, 8'd3);
    reg_wr(2'd1, 8'd2);
    chk(src_sel == 2'd0, "R12 src before update", int'(src_sel), 0);
    issue(1'b1, 1'b0);
    wait_done("R3 div update");
    chk(src_sel == 2'd2, "R12 src after update", int'(src_sel), 2);
    check_off("R8 still disabled after divider load");
    reg_wr(2'd2, 8'd1);
    issue(1'b1, 1'b0);
    wait_done("R3 enable update");
    check_div(3, "R7 div3");
  endtask

  task automatic t_live_changes;
    reg_wr(2'd0, 8'd1);
    check_div(3, "R2 div shadow not live");
    issue(1'b1, 1'b0);
    wait_done("R3 div1 update");
    check_div(1, "R7 div1");
    reg_wr(2'd0, 8'd5);
    issue(1'b1, 1'b0);
    wait_done("R3 div5 update");
    check_div(5, "R7 div5");
  endtask

  task automatic t_wait_data;
    xfer_busy = 1'b1;
    reg_wr(2'd0, 8'd2);
    issue(1'b1, 1'b1);
    repeat (20) @(negedge clk);
    #1;
    chk(upd_busy, "R4 held busy", int'(upd_busy), 1);
    issue(1'b1, 1'b0);               // R10: ignored while pending
    repeat (20) @(negedge clk);
    #1;
    chk(upd_busy, "R10 second command ignored", int'(upd_busy), 1);
    check_div(5, "R4 old clock kept");
    xfer_busy = 1'b0;
    wait_done("R4 load after data");
    check_div(2, "R4 new clock");
  endtask

  task automatic t_no_wait;
    xfer_busy = 1'b1;
    reg_wr(2'd0, 8'd4);
    issue(1'b1, 1'b0);
    wait_done("R5 no wait completes");
    check_div(4, "R5 div4");
    xfer_busy = 1'b0;
  endtask

  task automatic t_back_to_bypass;
    reg_wr(2'd0, 8'd0);
    issue(1'b1, 1'b0);
    wait_done("R3 bypass update");
    check_bypass("R6 pass-through again");
    reg_wr(2'd2, 8'd0);
    issue(1'b1, 1'b0);
    wait_done("R3 final stop");
    check_off("R8 final stop");
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_no_start();
    t_bypass_on();
    t_change_seq();
    t_live_changes();
    t_wait_data();
    t_no_wait();
    t_back_to_bypass();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule